// File: doc/BRIEF.md
# MESI Line Controller with Single-Line Atomic Lock

This block keeps the coherence state of a small private cache that belongs to one core in a multi-core system. The cache is direct-mapped: each address owns one line slot, and each slot holds one data word and one of four states (Modified, Exclusive, Shared, Invalid). The core sends loads, stores, compare-and-swap and fetch-add requests. The controller serves hits locally. On a miss, or when it needs ownership, it raises a bus request and waits for a grant. The grant may come with fill data.

Other cores reach the cache through a snoop port. A share snoop demotes the line to Shared. An ownership snoop invalidates it. In both cases a dirty line returns its word. While a local operation works on a line, that line is locked. Snoops aimed at it are held back with a stall until the store part has been written. Snoops to any other line are answered at once. Atomic operations that miss ask for the line with ownership directly, so a locked operation costs at most one bus transaction.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `req_ready` is 1, `bus_req_valid` is 0, and a first load of any line goes to the bus.
- R2: A load (op 0) to an Invalid line issues bus kind 1 (read-shared) and leaves the line Shared. A load that hits in S, E or M issues no bus request and returns the stored word.
- R3: A store (op 1) or atomic to a Shared line issues bus kind 3 (upgrade). A store or atomic to a line in E or M issues no bus request. A completed store leaves the line Modified.
- R4: A compare-and-swap (op 2) or fetch-add (op 3) to an Invalid line issues bus kind 2 (read-for-ownership), never kind 1. The line is then filled in the Exclusive state.
- R5: An accepted share snoop (`snp_kind` 0) on a valid line reports hit. From M it reports dirty with the word and goes to S. From E it reports not dirty and goes to S.
- R6: An accepted ownership snoop (`snp_kind` 1) leaves the line Invalid. A Modified line supplies its word with dirty set.
- R7: A snoop to the line held by an ongoing local operation sees `snp_stall` high until the store part completes. A snoop to a different line is answered without stall.
- R8: A pending upgrade whose line is invalidated by a snoop before its grant is presented as bus kind 2 when granted. The request address stays stable until the grant.
- R9: Compare-and-swap writes the new word only on a match and returns the old word in both cases. Fetch-add returns the old word and stores old plus operand modulo 2^DATA_W. A failed compare still takes the line exclusively.
- R10: Two controllers sharing a snoop bus never both own a line. Concurrent fetch-adds from both cores therefore see distinct old values and produce the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 2 | 0 load, 1 store, 2 compare-and-swap, 3 fetch-add |
| req_addr | input | IW | Line index |
| req_wdata | input | DATA_W | Store value, swap value or addend |
| req_cmp | input | DATA_W | Compare value for compare-and-swap |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Loaded word or old word, valid with rsp_done |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_kind | output | 2 | 1 read-shared, 2 read-for-ownership, 3 upgrade |
| bus_req_addr | output | IW | Line index of the bus request |
| bus_grant | input | 1 | Request granted (one cycle) |
| bus_fill_valid | input | 1 | Fill word present with the grant |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Snoop present |
| snp_kind | input | 1 | 0 share, 1 ownership |
| snp_addr | input | IW | Snooped line index |
| snp_stall | output | 1 | Snoop held back, keep it asserted |
| snp_hit | output | 1 | Accepted snoop found a valid line |
| snp_dirty | output | 1 | Accepted snoop found a Modified line |
| snp_data | output | DATA_W | Word supplied by a dirty line |

## Verification
The bench builds two controllers with NLINES = 4 and DATA_W = 16, joined by a serializing arbiter and a word-per-line memory. Four lines are enough to hold an atomic on one line while the peer snoops another. The 16-bit word lets a fetch-add wrap past 0xFFFF in a few operations. Because both controllers' requests are accepted on the same edge, the upgrade-versus-upgrade race and the stall on a locked line are reached deterministically.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_E = 2'd2,
    LN_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CAS   = 2'd2,
    OP_FADD  = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_SHARED = 2'd1,
    BK_OWN    = 2'd2,
    BK_UPG    = 2'd3
  } bus_kind_t;

  localparam logic SK_SHARE = 1'b0;
  localparam logic SK_OWN   = 1'b1;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(NLINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         a_idx,
  output line_st_t              a_st,
  output logic [DATA_W-1:0]     a_dat,
  input  logic [IW-1:0]         b_idx,
  output line_st_t              b_st,
  output logic [DATA_W-1:0]     b_dat,
  input  logic                  snp_we,
  input  logic [IW-1:0]         snp_idx,
  input  line_st_t              snp_st,
  input  logic                  loc_st_we,
  input  logic                  loc_dat_we,
  input  logic [IW-1:0]         loc_idx,
  input  line_st_t              loc_st,
  input  logic [DATA_W-1:0]     loc_dat,
  output logic [2*NLINES-1:0]   st_flat
);

  line_st_t          st_q  [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic loc_sel, snp_sel;
    assign loc_sel = (loc_idx == IW'(g));
    assign snp_sel = (snp_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= LN_I;
        dat_q[g] <= '0;
      end else begin
        if (loc_st_we && loc_sel)      st_q[g] <= loc_st;
        else if (snp_we && snp_sel)    st_q[g] <= snp_st;
        if (loc_dat_we && loc_sel)     dat_q[g] <= loc_dat;
      end
    end

    assign st_flat[2*g +: 2] = st_q[g];
  end

  assign a_st  = st_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_dat = dat_q[b_idx];

  // R7
  no_update_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_st_we && snp_we && (loc_idx == snp_idx)));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic              lock_hit,
  input  line_st_t          line_st,
  input  logic [DATA_W-1:0] line_dat,
  output logic              stall,
  output logic              hit,
  output logic              dirty,
  output logic [DATA_W-1:0] rdat,
  output logic              upd_we,
  output line_st_t          upd_st
);

  function automatic line_st_t snoop_next(input logic kind);
    return (kind == SK_OWN) ? LN_I : LN_S;
  endfunction

  logic accept;

  assign accept = snp_valid && !lock_hit;
  assign stall  = snp_valid && lock_hit;
  assign hit    = accept && (line_st != LN_I);
  assign dirty  = accept && (line_st == LN_M);
  assign rdat   = dirty ? line_dat : '0;
  assign upd_we = hit;
  assign upd_st = snoop_next(snp_kind);

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [IW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_cmp,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_kind,
  output logic [IW-1:0]     bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  output logic [IW-1:0]     line_idx,
  input  line_st_t          cur_st,
  input  logic [DATA_W-1:0] cur_dat,
  output logic              loc_st_we,
  output line_st_t          loc_st,
  output logic              loc_dat_we,
  output logic [DATA_W-1:0] loc_dat,
  output logic              lock_active
);

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_CHECK, RQ_BUS, RQ_EXEC, RQ_WR
  } rq_t;

  function automatic logic [DATA_W-1:0] rmw_value(
    input op_t op, input logic [DATA_W-1:0] old,
    input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] cmp);
    if (op == OP_FADD)      return old + wd;
    else if (op == OP_CAS)  return (old == cmp) ? wd : old;
    else                    return wd;
  endfunction

  function automatic logic rmw_writes(
    input op_t op, input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] cmp);
    return (op == OP_FADD) || (old == cmp);
  endfunction

  rq_t               rq_q;
  op_t               op_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] wd_q, cmp_q, old_q;

  logic      is_load, is_atomic, owned, need_bus, granted;
  bus_kind_t kind_w;

  assign is_load   = (op_q == OP_LOAD);
  assign is_atomic = (op_q == OP_CAS) || (op_q == OP_FADD);
  assign owned     = (cur_st == LN_E) || (cur_st == LN_M);
  assign need_bus  = is_load ? (cur_st == LN_I) : !owned;
  assign granted   = (rq_q == RQ_BUS) && bus_grant;

  always_comb begin
    if (rq_q != RQ_BUS)        kind_w = BK_NONE;
    else if (is_load)          kind_w = BK_SHARED;
    else if (cur_st == LN_S)   kind_w = BK_UPG;
    else                       kind_w = BK_OWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q  <= RQ_IDLE;
      op_q  <= OP_LOAD;
      idx_q <= '0;
      wd_q  <= '0;
      cmp_q <= '0;
      old_q <= '0;
    end else begin
      case (rq_q)
        RQ_IDLE: if (req_valid) begin
          op_q  <= op_t'(req_op);
          idx_q <= req_addr;
          wd_q  <= req_wdata;
          cmp_q <= req_cmp;
          rq_q  <= RQ_CHECK;
        end
        RQ_CHECK: rq_q <= need_bus ? RQ_BUS : RQ_EXEC;
        RQ_BUS:   if (bus_grant) rq_q <= RQ_EXEC;
        RQ_EXEC: begin
          if (is_atomic) begin
            old_q <= cur_dat;
            rq_q  <= RQ_WR;
          end else begin
            rq_q <= RQ_IDLE;
          end
        end
        default: rq_q <= RQ_IDLE;
      endcase
    end
  end

  always_comb begin
    loc_st_we  = 1'b0;
    loc_st     = LN_I;
    loc_dat_we = 1'b0;
    loc_dat    = '0;
    if (granted) begin
      loc_st_we  = 1'b1;
      loc_st     = is_load ? LN_S : LN_E;
      loc_dat_we = bus_fill_valid && (kind_w != BK_UPG);
      loc_dat    = bus_fill_data;
    end else if (rq_q == RQ_EXEC && op_q == OP_STORE) begin
      loc_st_we  = 1'b1;
      loc_st     = LN_M;
      loc_dat_we = 1'b1;
      loc_dat    = wd_q;
    end else if (rq_q == RQ_WR && rmw_writes(op_q, old_q, cmp_q)) begin
      loc_st_we  = 1'b1;
      loc_st     = LN_M;
      loc_dat_we = 1'b1;
      loc_dat    = rmw_value(op_q, old_q, wd_q, cmp_q);
    end
  end

  assign req_ready     = (rq_q == RQ_IDLE);
  assign bus_req_valid = (rq_q == RQ_BUS);
  assign bus_req_kind  = kind_w;
  assign bus_req_addr  = idx_q;
  assign line_idx      = idx_q;
  assign rsp_done      = ((rq_q == RQ_EXEC) && !is_atomic) || (rq_q == RQ_WR);
  assign rsp_rdata     = (rq_q == RQ_WR) ? old_q : cur_dat;
  assign lock_active   = (rq_q == RQ_CHECK) || (rq_q == RQ_EXEC) || (rq_q == RQ_WR);

  // R3
  upgrade_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_kind == BK_UPG) |-> (cur_st == LN_S));

  // R3
  commit_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_st_we && loc_st == LN_M) |-> (cur_st == LN_E || cur_st == LN_M));

  // R4
  atomic_never_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && is_atomic) |-> (bus_req_kind != BK_SHARED));

  // R8
  bus_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant) |=> (bus_req_valid && $stable(bus_req_addr)));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [IW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_cmp,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_kind,
  output logic [IW-1:0]     bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic              snp_kind,
  input  logic [IW-1:0]     snp_addr,
  output logic              snp_stall,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);

  logic [IW-1:0]       line_idx;
  line_st_t            cur_st, snp_line_st, loc_st, snp_upd_st;
  logic [DATA_W-1:0]   cur_dat, snp_line_dat, loc_dat;
  logic                loc_st_we, loc_dat_we, snp_upd_we, lock_active, lock_hit;
  logic [2*NLINES-1:0] st_flat;

  assign lock_hit = lock_active && (line_idx == snp_addr);

  mesi_req_ctrl #(.NLINES(NLINES), .DATA_W(DATA_W)) u_req (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_op, .req_addr, .req_wdata, .req_cmp,
    .rsp_done, .rsp_rdata,
    .bus_req_valid, .bus_req_kind, .bus_req_addr,
    .bus_grant, .bus_fill_valid, .bus_fill_data,
    .line_idx, .cur_st, .cur_dat,
    .loc_st_we, .loc_st, .loc_dat_we, .loc_dat,
    .lock_active
  );

  mesi_snoop_resp #(.DATA_W(DATA_W)) u_snp (
    .snp_valid, .snp_kind, .lock_hit,
    .line_st (snp_line_st),
    .line_dat(snp_line_dat),
    .stall   (snp_stall),
    .hit     (snp_hit),
    .dirty   (snp_dirty),
    .rdat    (snp_data),
    .upd_we  (snp_upd_we),
    .upd_st  (snp_upd_st)
  );

  mesi_line_store #(.NLINES(NLINES), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .a_idx(line_idx), .a_st(cur_st), .a_dat(cur_dat),
    .b_idx(snp_addr), .b_st(snp_line_st), .b_dat(snp_line_dat),
    .snp_we(snp_upd_we), .snp_idx(snp_addr), .snp_st(snp_upd_st),
    .loc_st_we, .loc_dat_we, .loc_idx(line_idx), .loc_st, .loc_dat,
    .st_flat
  );

  logic          acc_q, acc_kind_q, acc_hit_q;
  logic [IW-1:0] acc_idx_q;
  logic [1:0]    acc_line_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= 1'b0;
      acc_kind_q <= 1'b0;
      acc_hit_q  <= 1'b0;
      acc_idx_q  <= '0;
    end else begin
      acc_q      <= snp_valid && !snp_stall;
      acc_kind_q <= snp_kind;
      acc_hit_q  <= snp_hit;
      acc_idx_q  <= snp_addr;
    end
  end

  assign acc_line_now = st_flat[{acc_idx_q, 1'b0} +: 2];

  // R6
  own_snoop_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && acc_kind_q == SK_OWN) |-> (acc_line_now == LN_I));

  // R5
  share_snoop_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && acc_kind_q == SK_SHARE && acc_hit_q) |-> (acc_line_now == LN_S));

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  import mesi_pkg::*;

  localparam int NL = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid [2];
  logic          req_ready [2];
  logic [1:0]    req_op [2];
  logic [IW-1:0] req_addr [2];
  logic [DW-1:0] req_wdata [2], req_cmp [2];
  logic          rsp_done [2];
  logic [DW-1:0] rsp_rdata [2];
  logic          bus_req_valid [2];
  logic [1:0]    bus_req_kind [2];
  logic [IW-1:0] bus_req_addr [2];
  logic          bus_grant [2], bus_fill_valid [2];
  logic [DW-1:0] bus_fill_data [2];
  logic          snp_valid [2], snp_kind [2];
  logic [IW-1:0] snp_addr [2];
  logic          snp_stall [2], snp_hit [2], snp_dirty [2];
  logic [DW-1:0] snp_data [2];

  mesi_line_ctrl #(.NLINES(NL), .DATA_W(DW)) uut (
    .clk, .rst_n,
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_op(req_op[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]), .req_cmp(req_cmp[0]),
    .rsp_done(rsp_done[0]), .rsp_rdata(rsp_rdata[0]),
    .bus_req_valid(bus_req_valid[0]), .bus_req_kind(bus_req_kind[0]),
    .bus_req_addr(bus_req_addr[0]), .bus_grant(bus_grant[0]),
    .bus_fill_valid(bus_fill_valid[0]), .bus_fill_data(bus_fill_data[0]),
    .snp_valid(snp_valid[0]), .snp_kind(snp_kind[0]), .snp_addr(snp_addr[0]),
    .snp_stall(snp_stall[0]), .snp_hit(snp_hit[0]), .snp_dirty(snp_dirty[0]),
    .snp_data(snp_data[0])
  );

  mesi_line_ctrl #(.NLINES(NL), .DATA_W(DW)) peer (
    .clk, .rst_n,
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_op(req_op[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]), .req_cmp(req_cmp[1]),
    .rsp_done(rsp_done[1]), .rsp_rdata(rsp_rdata[1]),
    .bus_req_valid(bus_req_valid[1]), .bus_req_kind(bus_req_kind[1]),
    .bus_req_addr(bus_req_addr[1]), .bus_grant(bus_grant[1]),
    .bus_fill_valid(bus_fill_valid[1]), .bus_fill_data(bus_fill_data[1]),
    .snp_valid(snp_valid[1]), .snp_kind(snp_kind[1]), .snp_addr(snp_addr[1]),
    .snp_stall(snp_stall[1]), .snp_hit(snp_hit[1]), .snp_dirty(snp_dirty[1]),
    .snp_data(snp_data[1])
  );

  logic [DW-1:0] mem [NL];
  int            bus_cnt [2];
  logic [1:0]    last_kind [2];
  logic          last_hit [2], last_dirty [2];
  logic [DW-1:0] last_sdata [2];
  int            last_stall [2];
  int            max_stall;
  int            n_chk = 0, n_fail = 0;
  bit            done_flag = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Serializing bus arbiter with a word-per-line memory
  initial begin
    int prio = 0;
    for (int c = 0; c < 2; c++) begin
      bus_grant[c] = 0; bus_fill_valid[c] = 0; bus_fill_data[c] = '0;
      snp_valid[c] = 0; snp_kind[c] = 0; snp_addr[c] = '0;
      bus_cnt[c] = 0; last_kind[c] = '0; last_hit[c] = 0; last_dirty[c] = 0;
      last_sdata[c] = '0; last_stall[c] = 0;
    end
    max_stall = 0;
    for (int i = 0; i < NL; i++) mem[i] = DW'(16'h1000 + i * 16'h0011);
    forever begin
      int pick;
      @(negedge clk);
      pick = -1;
      if (bus_req_valid[prio]) pick = prio;
      else if (bus_req_valid[1-prio]) pick = 1 - prio;
      if (pick >= 0) begin
        int o, stalls;
        logic [IW-1:0] a;
        logic [1:0] k;
        bit got;
        o = 1 - pick;
        prio = o;
        a = bus_req_addr[pick];
        k = bus_req_kind[pick];
        bus_cnt[pick]++;
        last_kind[pick] = k;
        snp_addr[o] = a;
        snp_kind[o] = (k == BK_SHARED) ? SK_SHARE : SK_OWN;
        snp_valid[o] = 1;
        stalls = 0;
        got = 0;
        while (!got) begin
          #2;
          if (!snp_stall[o]) begin
            last_hit[o] = snp_hit[o];
            last_dirty[o] = snp_dirty[o];
            last_sdata[o] = snp_data[o];
            if (snp_dirty[o]) mem[a] = snp_data[o];
            got = 1;
          end else begin
            stalls++;
          end
          @(negedge clk);
        end
        snp_valid[o] = 0;
        last_stall[o] = stalls;
        if (stalls > max_stall) max_stall = stalls;
        bus_grant[pick] = 1;
        bus_fill_valid[pick] = (k != BK_UPG);
        bus_fill_data[pick] = mem[a];
        @(negedge clk);
        bus_grant[pick] = 0;
        bus_fill_valid[pick] = 0;
      end
    end
  end

  task automatic do_op(input int c, input logic [1:0] op, input logic [IW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cm,
                       output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid[c] = 1; req_op[c] = op; req_addr[c] = a;
    req_wdata[c] = wd; req_cmp[c] = cm;
    while (!req_ready[c]) @(negedge clk);
    @(negedge clk);
    req_valid[c] = 0;
    while (!rsp_done[c]) @(negedge clk);
    rd = rsp_rdata[c];
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd;
    int b;
    @(negedge clk);
    check("R1 ready core0", req_ready[0], 1);
    check("R1 ready core1", req_ready[1], 1);
    check("R1 no bus req", {bus_req_valid[0], bus_req_valid[1]}, 0);
    b = bus_cnt[0];
    do_op(0, OP_LOAD, 2'd1, 0, 0, rd);
    check("R1 first load uses bus", bus_cnt[0], b + 1);
    check("R2 miss kind read-shared", last_kind[0], BK_SHARED);
    check("R2 miss data", rd, 16'h1011);
    check("R1 peer snoop misses", last_hit[1], 0);
  endtask

  task automatic t_share();
    logic [DW-1:0] rd;
    int b;
    do_op(1, OP_LOAD, 2'd1, 0, 0, rd);
    check("R2 peer load kind", last_kind[1], BK_SHARED);
    check("R5 shared copy hit", last_hit[0], 1);
    check("R5 shared copy clean", last_dirty[0], 0);
    b = bus_cnt[0];
    do_op(0, OP_LOAD, 2'd1, 0, 0, rd);
    check("R2 hit in S no bus", bus_cnt[0], b);
    check("R2 hit data", rd, 16'h1011);
  endtask

  task automatic t_upgrade();
    logic [DW-1:0] rd;
    int b;
    do_op(0, OP_STORE, 2'd1, 16'hAAAA, 0, rd);
    check("R3 store in S kind", last_kind[0], BK_UPG);
    check("R6 peer S copy hit", last_hit[1], 1);
    b = bus_cnt[0];
    do_op(0, OP_STORE, 2'd1, 16'hBBBB, 0, rd);
    check("R3 store in M no bus", bus_cnt[0], b);
    do_op(1, OP_LOAD, 2'd1, 0, 0, rd);
    check("R6 invalidated peer refetches", last_kind[1], BK_SHARED);
    check("R5 dirty supplier", last_dirty[0], 1);
    check("R5 supplied word", last_sdata[0], 16'hBBBB);
    check("R5 load sees update", rd, 16'hBBBB);
    b = bus_cnt[0];
    do_op(0, OP_STORE, 2'd1, 16'hCCCC, 0, rd);
    check("R5 M demoted to S then upgrade", last_kind[0], BK_UPG);
    check("R5 single upgrade", bus_cnt[0], b + 1);
  endtask

  task automatic t_exclusive();
    logic [DW-1:0] rd;
    do_op(0, OP_CAS, 2'd0, 16'h5555, 16'h0BAD, rd);
    check("R4 cas miss kind", last_kind[0], BK_OWN);
    check("R9 failed cas old", rd, 16'h1000);
    do_op(1, OP_LOAD, 2'd0, 0, 0, rd);
    check("R5 E line hit", last_hit[0], 1);
    check("R5 E line clean", last_dirty[0], 0);
    check("R9 failed cas left word", rd, 16'h1000);
    do_op(0, OP_STORE, 2'd0, 16'h0E0E, 0, rd);
    check("R5 E demoted to S", last_kind[0], BK_UPG);
  endtask

  task automatic t_atomics();
    logic [DW-1:0] rd;
    int b;
    do_op(1, OP_FADD, 2'd2, 16'h0005, 0, rd);
    check("R4 fadd miss kind", last_kind[1], BK_OWN);
    check("R9 fadd old", rd, 16'h1022);
    b = bus_cnt[1];
    do_op(1, OP_CAS, 2'd2, 16'h1234, 16'h1022, rd);
    check("R9 cas mismatch old", rd, 16'h1027);
    do_op(1, OP_CAS, 2'd2, 16'h1234, 16'h1027, rd);
    check("R9 cas match old", rd, 16'h1027);
    check("R3 owned atomics no bus", bus_cnt[1], b);
    do_op(0, OP_LOAD, 2'd2, 0, 0, rd);
    check("R9 cas stored word", rd, 16'h1234);
    do_op(1, OP_STORE, 2'd3, 16'hFFFF, 0, rd);
    do_op(1, OP_FADD, 2'd3, 16'h0002, 0, rd);
    check("R9 wrap old", rd, 16'hFFFF);
    do_op(0, OP_LOAD, 2'd3, 0, 0, rd);
    check("R9 wrap result", rd, 16'h0001);
  endtask

  task automatic t_other_line();
    logic [DW-1:0] r0, r1;
    fork
      do_op(0, OP_FADD, 2'd0, 16'h0001, 0, r0);
      do_op(1, OP_LOAD, 2'd1, 0, 0, r1);
    join
    check("R7 other line no stall", last_stall[0], 0);
    check("R7 other line data", r1, 16'hCCCC);
    check("R7 locked atomic old", r0, 16'h0E0E);
  endtask

  task automatic t_lock_race();
    logic [DW-1:0] r0, r1, rf;
    int upg, own;
    max_stall = 0;
    fork
      do_op(0, OP_FADD, 2'd3, 16'h0010, 0, r0);
      do_op(1, OP_FADD, 2'd3, 16'h0100, 0, r1);
    join
    check("R7 same line stalled", (max_stall >= 1), 1);
    upg = (last_kind[0] == BK_UPG) + (last_kind[1] == BK_UPG);
    own = (last_kind[0] == BK_OWN) + (last_kind[1] == BK_OWN);
    check("R8 one upgrade", upg, 1);
    check("R8 loser became ownership", own, 1);
    check("R10 old values ordered", ((r0 == 16'h0001 && r1 == 16'h0011) ||
                                     (r1 == 16'h0001 && r0 == 16'h0101)), 1);
    do_op(0, OP_LOAD, 2'd3, 0, 0, rf);
    check("R10 race sum", rf, 16'h0111);
  endtask

  task automatic t_sum();
    logic [DW-1:0] base, fin;
    logic [DW-1:0] olds [40];
    logic [DW-1:0] exp;
    int dup;
    do_op(0, OP_LOAD, 2'd2, 0, 0, base);
    exp = base;
    for (int i = 0; i < 20; i++) exp = exp + DW'(i + 1) + DW'(100 + i);
    fork
      for (int i = 0; i < 20; i++) do_op(0, OP_FADD, 2'd2, DW'(i + 1), 0, olds[i]);
      for (int i = 0; i < 20; i++) do_op(1, OP_FADD, 2'd2, DW'(100 + i), 0, olds[20 + i]);
    join
    do_op(1, OP_LOAD, 2'd2, 0, 0, fin);
    check("R10 exact sum", fin, exp);
    dup = 0;
    for (int i = 0; i < 40; i++)
      for (int j = i + 1; j < 40; j++)
        if (olds[i] == olds[j]) dup++;
    check("R10 distinct old values", dup, 0);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      req_valid[c] = 0; req_op[c] = '0; req_addr[c] = '0;
      req_wdata[c] = '0; req_cmp[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_share();
    t_upgrade();
    t_exclusive();
    t_atomics();
    t_other_line();
    t_lock_race();
    t_sum();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule